// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A one-cycle start pulse loads a 9-bit starting column, a burst-length code and a burst-order bit. From the next clock on, the block presents one column address per cycle, together with a beat index, a valid flag and a flag marking the final beat.

The burst order is either sequential or interleaved. Sequential order counts upward from the start column but stays inside the block of addresses that is aligned to the burst length, so it wraps instead of carrying into higher bits. Interleaved order XORs the low bits of the start column with the beat index. In both orders the column bits above the burst boundary do not change during the burst.

A new start pulse aborts any burst in progress. A stop input cuts the burst short. Command decoding, bank and row handling, and the data path stay with the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start pulse, colValid and lastBeat are low.
- R2: The cycle after a start pulse is sampled, colValid is high, beatIdx is 0 and colAddr equals the sampled startCol.
- R3: burstLenSel encodes the beat count as 2'b00 = 2, 2'b01 = 4, 2'b10 = 8 and 2'b11 = 8. An uninterrupted burst shows that many consecutive valid beats, with beatIdx running 0, 1, 2 and upward.
- R4: With burstType = 0 (sequential), the low log2(N) bits of colAddr on beat k are (start + k) mod N, and no carry passes into higher bits.
- R5: With burstType = 1 (interleave), the low log2(N) bits of colAddr on beat k are the start's low bits XOR k.
- R6: Column bits at and above position log2(N) stay equal to the start column's bits on every beat.
- R7: lastBeat is high only together with the final beat's address. colValid falls on the next cycle unless a new start pulse is present.
- R8: burstLenSel, burstType and startCol are captured only on a start pulse. Changes to them during a burst do not alter that burst.
- R9: A start pulse during an active burst abandons it. The new burst's first beat appears on the next cycle.
- R10: stopReq sampled high during a burst makes colValid low on the next cycle. A start pulse in the same cycle takes priority and begins a new burst.
- R11: stopReq while idle has no effect: colValid and lastBeat stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Loads a new burst |
| startCol | input | 9 | Starting column address |
| burstLenSel | input | 2 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleave |
| stopReq | input | 1 | Ends the active burst |
| colAddr | output | 9 | Column address for the current beat |
| beatIdx | output | 3 | Index of the current beat |
| colValid | output | 1 | colAddr and beatIdx are meaningful |
| lastBeat | output | 1 | Current beat is the final one |

## Verification
Sequential and interleaved bursts are run at every length from start columns whose low bits are non-zero and whose high bits are set, for example 0x1FD. This separates wrapping within the aligned block from plain incrementing, and an XOR ordering from a sum. A length code of 2'b11 and inputs that change during a burst confirm that the settings are captured at the start. Restart, stop, stop together with start, and stop while idle check the priority between terminations and new bursts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture start settings, zero beat counter
    logic step;  // advance to next beat
  } seqStrobe_t;

  typedef enum logic [1:0] {
    LEN_2   = 2'b00,
    LEN_4   = 2'b01,
    LEN_8   = 2'b10,
    LEN_8B  = 2'b11
  } burstLen_e;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic [1:0]        burstLenSel,
  input  logic              stopReq,
  input  logic [BEAT_W-1:0] beatIdx,
  output seqStrobe_t        strobe,
  output logic [BEAT_W-1:0] lenMask,
  output logic              active,
  output logic              isLast
);
  logic [BEAT_W-1:0] newMask;

  // mask bit i set when the burst spans address bit i
  always_comb begin
    for (int i = 0; i < BEAT_W; i++) begin
      newMask[i] = (i <= int'(burstLenSel));
    end
  end

  assign isLast = active && (beatIdx == lenMask);

  always_comb begin
    strobe.load = startPulse;
    strobe.step = active && !isLast && !stopReq && !startPulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      lenMask <= '0;
    end else if (startPulse) begin
      active  <= 1'b1;
      lenMask <= newMask;
    end else if (active && (stopReq || isLast)) begin
      active  <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_seq_dpath.sv
module burst_seq_dpath
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [COL_W-1:0]  startCol,
  input  logic              burstType,
  input  logic [BEAT_W-1:0] lenMask,
  output logic [COL_W-1:0]  colAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  logic [COL_W-1:0]  baseCol;
  logic              typeReg;
  logic [BEAT_W-1:0] seqLow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseCol <= '0;
      typeReg <= 1'b0;
      beatIdx <= '0;
    end else if (strobe.load) begin
      baseCol <= startCol;
      typeReg <= burstType;
      beatIdx <= '0;
    end else if (strobe.step) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  // sequential low bits: sum truncated, carry dropped by mask below
  assign seqLow = baseCol[BEAT_W-1:0] + beatIdx;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      if (b < BEAT_W) begin : g_low
        always_comb begin
          if (!lenMask[b])
            colAddr[b] = baseCol[b];
          else if (typeReg)
            colAddr[b] = baseCol[b] ^ beatIdx[b];
          else
            colAddr[b] = seqLow[b];
        end
      end else begin : g_high
        assign colAddr[b] = baseCol[b];
      end
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic [COL_W-1:0]  startCol,
  input  logic [1:0]        burstLenSel,
  input  logic              burstType,
  input  logic              stopReq,
  output logic [COL_W-1:0]  colAddr,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              colValid,
  output logic              lastBeat
);
  seqStrobe_t        strobe;
  logic [BEAT_W-1:0] lenMask;

  burst_seq_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse),
    .burstLenSel(burstLenSel), .stopReq(stopReq), .beatIdx(beatIdx),
    .strobe(strobe), .lenMask(lenMask), .active(colValid), .isLast(lastBeat)
  );

  burst_seq_dpath #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .startCol(startCol),
    .burstType(burstType), .lenMask(lenMask), .colAddr(colAddr),
    .beatIdx(beatIdx)
  );
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              startPulse,
  input logic [COL_W-1:0]  startCol,
  input logic              stopReq,
  input logic [COL_W-1:0]  colAddr,
  input logic [BEAT_W-1:0] beatIdx,
  input logic              colValid,
  input logic              lastBeat
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !colValid);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (colValid && beatIdx == '0 && colAddr == $past(startCol)));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (colValid && !lastBeat && !stopReq && !startPulse) |=>
      (colValid && beatIdx == $past(beatIdx) + 1'b1));

  // R6
  high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (colValid && !startPulse) |=>
      (!colValid || $stable(colAddr[COL_W-1:BEAT_W])));

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> colValid);

  // R7
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !startPulse) |=> !colValid);

  // R10
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopReq && !startPulse) |=> !colValid);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .startCol(startCol),
  .stopReq(stopReq), .colAddr(colAddr), .beatIdx(beatIdx),
  .colValid(colValid), .lastBeat(lastBeat)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startPulse = 1'b0;
  logic [8:0] startCol = '0;
  logic [1:0] burstLenSel = '0;
  logic       burstType = 1'b0;
  logic       stopReq = 1'b0;
  logic [8:0] colAddr;
  logic [2:0] beatIdx;
  logic       colValid;
  logic       lastBeat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .startCol(startCol),
    .burstLenSel(burstLenSel), .burstType(burstType), .stopReq(stopReq),
    .colAddr(colAddr), .beatIdx(beatIdx), .colValid(colValid),
    .lastBeat(lastBeat)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int beatsOf(input logic [1:0] code);
    return (code == 2'b00) ? 2 : (code == 2'b01) ? 4 : 8;
  endfunction

  function automatic int expAddr(input int col, input int n, input bit il, input int k);
    int m = n - 1;
    if (il) return col ^ (k & m);
    return (col & ~m & 9'h1FF) | ((col + k) & m);
  endfunction

  // called at a negedge; returns at the negedge where beat 0 is visible
  task automatic launch(input logic [8:0] col, input logic [1:0] code, input bit il);
    startPulse = 1'b1; startCol = col; burstLenSel = code; burstType = il;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic expectBurst(input string req, input int col, input logic [1:0] code, input bit il);
    int n = beatsOf(code);
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, colValid, 1);
      chk({req, " beat"}, beatIdx, k);
      chk({req, " addr"}, colAddr, expAddr(col, n, il, k));
      chk({req, " last"}, lastBeat, (k == n - 1));
      @(negedge clk);
    end
    chk({req, " end R7"}, colValid, 0);
  endtask

  task automatic testReset();
    chk("R1 valid", colValid, 0);
    chk("R1 last", lastBeat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", colValid, 0);
  endtask

  task automatic testSequential();
    launch(9'h1FD, 2'b00, 1'b0); expectBurst("R4 R2 seq2", 'h1FD, 2'b00, 1'b0);
    launch(9'h1FD, 2'b01, 1'b0); expectBurst("R4 seq4", 'h1FD, 2'b01, 1'b0);
    launch(9'h1FD, 2'b10, 1'b0); expectBurst("R4 R6 seq8", 'h1FD, 2'b10, 1'b0);
    launch(9'h0A3, 2'b10, 1'b0); expectBurst("R4 seq8b", 'h0A3, 2'b10, 1'b0);
  endtask

  task automatic testInterleave();
    launch(9'h15B, 2'b00, 1'b1); expectBurst("R5 il2", 'h15B, 2'b00, 1'b1);
    launch(9'h15B, 2'b01, 1'b1); expectBurst("R5 il4", 'h15B, 2'b01, 1'b1);
    launch(9'h15B, 2'b10, 1'b1); expectBurst("R5 R6 il8", 'h15B, 2'b10, 1'b1);
  endtask

  task automatic testCode3();
    launch(9'h0C6, 2'b11, 1'b0); expectBurst("R3 code3", 'h0C6, 2'b11, 1'b0);
  endtask

  task automatic testCapture();
    launch(9'h013, 2'b00, 1'b0);
    startCol = 9'h1FF; burstLenSel = 2'b10; burstType = 1'b1;
    expectBurst("R8 capture", 'h013, 2'b00, 1'b0);
  endtask

  task automatic testRestart();
    launch(9'h020, 2'b10, 1'b0);
    @(negedge clk);
    chk("R9 before", beatIdx, 1);
    launch(9'h105, 2'b01, 1'b1);
    expectBurst("R9 restart", 'h105, 2'b01, 1'b1);
  endtask

  task automatic testStop();
    launch(9'h0F0, 2'b10, 1'b0);
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R10 stop valid", colValid, 0);
    chk("R10 stop last", lastBeat, 0);
    launch(9'h0F0, 2'b10, 1'b0);
    stopReq = 1'b1;
    launch(9'h033, 2'b00, 1'b0);
    stopReq = 1'b0;
    expectBurst("R10 stop+start", 'h033, 2'b00, 1'b0);
  endtask

  task automatic testStopIdle();
    stopReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 idle valid", colValid, 0);
      chk("R11 idle last", lastBeat, 0);
    end
    stopReq = 1'b0;
    launch(9'h044, 2'b01, 1'b0);
    expectBurst("R11 after", 'h044, 2'b01, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testSequential();
    testInterleave();
    testCode3();
    testCapture();
    testRestart();
    testStop();
    testStopIdle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule